// File: doc/BRIEF.md
# TDM Frame Receiver

This block is the receiving half of a controller that talks to an audio device over a 256-bit time-division serial link. The controller produces a frame-start strobe. Each frame opens with a 16-bit tag slot, and twelve 20-bit data slots follow it. The receiver takes one sample of the serial input on each sampling edge of the bit clock and follows the strobe to find where each frame starts. It turns the stream into parallel form: a device-ready flag, twelve per-slot valid flags and twelve 20-bit slot words.

The block runs on the sampling edge of the bit clock. In a system that samples on the falling edge, `clk` is the inverted bit clock. All slot bits of a frame first collect in staging registers. At frame end they are copied into the output bank, and a one-cycle done pulse marks the copy. A slot word changes only when its valid flag in that frame's tag is set, so the consumer always sees the last good sample of each slot. A strobe that rises anywhere other than the frame boundary forces the receiver to re-align and sets a sticky error flag.

Top module: `tdm_frame_rx`

## Requirements
- R1: A frame is 256 sample positions. Positions 0 to 15 form the tag. Slot n (1 to 12) covers positions 16+20(n-1) to 35+20(n-1), most significant bit first. Slot n is presented on `slot_data_o[20(n-1)+19 : 20(n-1)]`.
- R2: A sampling edge where `frame_strobe_i` is high and was low at the previous sampling edge is a strobe rise. Position 0 is the sample taken on the next sampling edge after a strobe rise.
- R3: At each commit, `dev_ready_o` takes the value sampled at tag position 0.
- R4: At each commit, `slot_valid_o[n-1]` takes the value sampled at tag position n, for n = 1 to 12.
- R5: At a commit, slot n's output word is replaced only when its tag valid bit in that frame is 1. Otherwise it keeps its previous value.
- R6: The values sampled at tag positions 13 to 15 have no effect on any output.
- R7: A commit happens on the sampling edge after the one that captures position 255. `frame_done_o` is high for exactly the one cycle that follows that commit. Outside that pulse, the ready, valid and data outputs do not change.
- R8: A strobe rise seen while locked at a position other than 255 has three effects. The next sample becomes position 0. `sync_err_o` goes to 1 and stays at 1 until reset. The partial frame is never committed.
- R9: A strobe rise that coincides with position 255, or the first rise after reset, leaves `sync_err_o` at 0.
- R10: While `rst_n` is low at a clock edge, the ready, valid, done and error outputs and all slot words are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one edge per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strobe_i | input | 1 | Frame-start strobe from the local frame generator |
| serial_i | input | 1 | Serial data from the device |
| dev_ready_o | output | 1 | Device-ready flag from the last committed tag |
| slot_valid_o | output | 12 | Per-slot valid flags from the last committed tag |
| slot_data_o | output | 240 | Twelve 20-bit slot words, slot 1 in the lowest bits |
| frame_done_o | output | 1 | One-cycle pulse after each commit |
| sync_err_o | output | 1 | Sticky flag for a misplaced strobe rise |

## Verification
If the position counter is off by even one, every slot word is shifted by a bit and the ready and valid flags take the wrong tag bit. This shows up at the first commit after the error, at most about 257 cycles later. Wrong valid gating shows as a held slot word that changes during a done pulse, or a valid word that fails to update. A mishandled misplaced strobe shows within one frame: either the error flag does not rise, or a done pulse and new data appear for the abandoned frame. The stimulus sends frames back to back with varied tags and data, one frame with only the unused tag bits set, and one frame that a misplaced strobe cuts short.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the TDM frame receiver.
// Assumes every slot holds the same number of bits and that the slot count
// fits in the tag after its ready bit.
package tdm_rx_pkg;
    localparam int TAG_W_D     = 16;
    localparam int SLOT_W_D    = 20;
    localparam int NUM_SLOTS_D = 12;
endpackage

// File: rtl/tdm_rx_align.sv
`timescale 1ns/1ps
// Frame alignment and bit-position counter.
// Finds strobe rises, restarts the position count after each one, and flags
// rises that do not land on the last position of a locked frame.
// Assumes the strobe is already synchronous to clk.
module tdm_rx_align #(
    parameter int FRAME_BITS = 256,
    parameter int POS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    output logic [POS_W-1:0] pos_o,
    output logic             locked_o,
    output logic             frame_end_o,
    output logic             sync_err_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic strobe_q;
    logic rise;

    assign rise = strobe_i & ~strobe_q;

    // Track strobe history, step the position and raise the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q    <= 1'b0;
            pos_o       <= '0;
            locked_o    <= 1'b0;
            frame_end_o <= 1'b0;
            sync_err_o  <= 1'b0;
        end else begin
            strobe_q    <= strobe_i;
            frame_end_o <= locked_o && (pos_o == LAST_POS);
            if (rise) begin
                pos_o    <= '0;
                locked_o <= 1'b1;
                if (locked_o && (pos_o != LAST_POS)) begin
                    sync_err_o <= 1'b1;
                end
            end else if (locked_o) begin
                pos_o <= (pos_o == LAST_POS) ? '0 : pos_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_rx_deser.sv
`timescale 1ns/1ps
// Deserializer for the tag and the data slots.
// Shifts each sample into the register that owns the current position.
// Only the ready and valid bits of the tag go out; the rest of the tag
// passes through the shift register only.
// Assumes pos_i is only meaningful while sample_en is high.
module tdm_rx_deser #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    parameter int POS_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_en,
    input  logic [POS_W-1:0]            pos_i,
    input  logic                        sdata_i,
    output logic [NUM_SLOTS:0]          flags_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] slots_o
);
    localparam logic [POS_W-1:0] TAG_HI = POS_W'(TAG_W - 1);

    logic [TAG_W-1:0] tag_sr;

    // Collect tag bits, first sample ending up in the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_sr <= '0;
        end else if (sample_en && (pos_i <= TAG_HI)) begin
            tag_sr <= {tag_sr[TAG_W-2:0], sdata_i};
        end
    end

    assign flags_o = tag_sr[TAG_W-1 -: NUM_SLOTS+1];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam int               LO   = TAG_W + k * SLOT_W;
        localparam logic [POS_W-1:0] LO_P = POS_W'(LO);
        localparam logic [POS_W-1:0] HI_P = POS_W'(LO + SLOT_W - 1);

        logic [SLOT_W-1:0] sr;

        // Shift in this slot's bits during its position window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr <= '0;
            end else if (sample_en && (pos_i >= LO_P) && (pos_i <= HI_P)) begin
                sr <= {sr[SLOT_W-2:0], sdata_i};
            end
        end

        assign slots_o[k*SLOT_W +: SLOT_W] = sr;
    end
endmodule

// File: rtl/tdm_rx_outbank.sv
`timescale 1ns/1ps
// Output bank.
// On a commit it copies the flags, and each valid slot word, from the
// staging registers to the outputs, and raises the done pulse.
// Assumes commit_i comes one cycle after the last position was sampled,
// so the staging registers are complete and not yet overwritten.
module tdm_rx_outbank #(
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [NUM_SLOTS:0]          flags_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] slots_i,
    output logic                        ready_o,
    output logic [NUM_SLOTS-1:0]        valid_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] data_o,
    output logic                        done_o
);
    logic [NUM_SLOTS-1:0] tag_valid;

    // Slot n's valid bit sits n places below the ready bit.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_vmap
        assign tag_valid[k] = flags_i[NUM_SLOTS-1-k];
    end

    // Update the ready and valid flags and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_o <= 1'b0;
            valid_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= commit_i;
            if (commit_i) begin
                ready_o <= flags_i[NUM_SLOTS];
                valid_o <= tag_valid;
            end
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_word
        // Replace a slot word only when the frame marks it valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[k*SLOT_W +: SLOT_W] <= '0;
            end else if (commit_i && tag_valid[k]) begin
                data_o[k*SLOT_W +: SLOT_W] <= slots_i[k*SLOT_W +: SLOT_W];
            end
        end
    end
endmodule

// File: rtl/tdm_frame_rx.sv
`timescale 1ns/1ps
// TDM frame receiver, top level.
// Locks to the frame strobe, deserializes the tag and the data slots, and
// shows them in parallel after each complete frame.
// Assumes clk is the sampling edge of the bit clock and that the strobe
// and serial input are synchronous to it.
module tdm_frame_rx
    import tdm_rx_pkg::*;
#(
    parameter int TAG_W     = TAG_W_D,
    parameter int SLOT_W    = SLOT_W_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_strobe_i,
    input  logic                        serial_i,
    output logic                        dev_ready_o,
    output logic [NUM_SLOTS-1:0]        slot_valid_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
    output logic                        frame_done_o,
    output logic                        sync_err_o
);
    localparam int FRAME_BITS = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int POS_W      = $clog2(FRAME_BITS);

    logic [POS_W-1:0]            pos;
    logic                        locked;
    logic                        frame_end;
    logic [NUM_SLOTS:0]          flags;
    logic [NUM_SLOTS*SLOT_W-1:0] staged;

    tdm_rx_align #(
        .FRAME_BITS(FRAME_BITS),
        .POS_W     (POS_W)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (frame_strobe_i),
        .pos_o      (pos),
        .locked_o   (locked),
        .frame_end_o(frame_end),
        .sync_err_o (sync_err_o)
    );

    tdm_rx_deser #(
        .TAG_W    (TAG_W),
        .SLOT_W   (SLOT_W),
        .NUM_SLOTS(NUM_SLOTS),
        .POS_W    (POS_W)
    ) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(locked),
        .pos_i    (pos),
        .sdata_i  (serial_i),
        .flags_o  (flags),
        .slots_o  (staged)
    );

    tdm_rx_outbank #(
        .SLOT_W   (SLOT_W),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(frame_end),
        .flags_i (flags),
        .slots_i (staged),
        .ready_o (dev_ready_o),
        .valid_o (slot_valid_o),
        .data_o  (slot_data_o),
        .done_o  (frame_done_o)
    );
endmodule

// File: rtl/tdm_frame_rx_chk.sv
`timescale 1ns/1ps
// Port-level checker for the TDM frame receiver, bound into the top level.
module tdm_frame_rx_chk #(
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frame_strobe_i,
    input logic                        dev_ready_o,
    input logic [NUM_SLOTS-1:0]        slot_valid_o,
    input logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
    input logic                        frame_done_o,
    input logic                        sync_err_o
);
    // R10: a reset edge leaves the flags cleared
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (!dev_ready_o && (slot_valid_o == '0) && !frame_done_o && !sync_err_o));

    // R7: the done pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R7: outputs move only together with the done pulse
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_o |-> $stable({dev_ready_o, slot_valid_o, slot_data_o}));

    // R8: the error flag never clears without reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |=> sync_err_o);

    // R8: the error flag rises only after a sampled strobe
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> $past(frame_strobe_i));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_hold
        // R5: an invalid slot keeps its word through a commit
        p_invalid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_done_o && !slot_valid_o[k]) |-> $stable(slot_data_o[k*SLOT_W +: SLOT_W]));
    end
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(
    .SLOT_W   (SLOT_W),
    .NUM_SLOTS(NUM_SLOTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_strobe_i(frame_strobe_i),
    .dev_ready_o   (dev_ready_o),
    .slot_valid_o  (slot_valid_o),
    .slot_data_o   (slot_data_o),
    .frame_done_o  (frame_done_o),
    .sync_err_o    (sync_err_o)
);

// File: tb/tdm_frame_rx_test.sv
`timescale 1ns/1ps
// Directed bench: each scenario task sends one frame. The results of a
// frame are checked at position 1 of the frame that follows it.
module tdm_frame_rx_test;
    localparam int NS = 12;
    localparam int SW = 20;
    localparam int DW = NS * SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic sdata = 1'b0;

    logic          dev_ready;
    logic [NS-1:0] slot_valid;
    logic [DW-1:0] slot_data;
    logic          frame_done;
    logic          sync_err;

    tdm_frame_rx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe_i(strobe),
        .serial_i      (sdata),
        .dev_ready_o   (dev_ready),
        .slot_valid_o  (slot_valid),
        .slot_data_o   (slot_data),
        .frame_done_o  (frame_done),
        .sync_err_o    (sync_err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic          exp_ready = 1'b0;
    logic [NS-1:0] exp_valid = '0;
    logic [DW-1:0] exp_data  = '0;
    logic          exp_err   = 1'b0;
    logic          pend      = 1'b0;
    logic [15:0]   pend_tag  = '0;
    logic [DW-1:0] pend_data = '0;
    string         pend_lbl  = "none";

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic bit_at(int i, logic [15:0] tg, logic [DW-1:0] dd);
        if (i < 16) begin
            return tg[15-i];
        end else begin
            int k = (i - 16) / SW;
            int b = (i - 16) % SW;
            return dd[k*SW + SW - 1 - b];
        end
    endfunction

    function automatic logic [15:0] mk_tag(logic rdy, logic [NS-1:0] v, logic [2:0] tail);
        logic [15:0] t = '0;
        t[15] = rdy;
        for (int k = 0; k < NS; k++) t[14-k] = v[k];
        t[2:0] = tail;
        return t;
    endfunction

    function automatic logic [DW-1:0] pattern(int seed);
        logic [DW-1:0] d = '0;
        for (int k = 0; k < NS; k++)
            d[k*SW +: SW] = 20'((seed * 32'h3A5C7) ^ (k * 32'h1F3D1) ^ 32'h80001);
        return d;
    endfunction

    // Sends one frame of cut positions. When cut is below 256 the next strobe
    // rise lands early. Checks the previous frame's results at position 1.
    task automatic send_frame(string lbl, logic [15:0] tg, logic [DW-1:0] dd, int cut);
        for (int i = 0; i < cut; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (pend) begin
                    exp_ready = pend_tag[15];
                    for (int k = 0; k < NS; k++) begin
                        exp_valid[k] = pend_tag[14-k];
                        if (pend_tag[14-k]) exp_data[k*SW +: SW] = pend_data[k*SW +: SW];
                    end
                end
                chk({"R7 done pulse after ", pend_lbl}, DW'(frame_done), DW'(pend));
                chk({"R3 ready after ", pend_lbl}, DW'(dev_ready), DW'(exp_ready));
                chk({"R4 valid after ", pend_lbl}, DW'(slot_valid), DW'(exp_valid));
                chk({"R1 R2 R5 data after ", pend_lbl}, slot_data, exp_data);
                chk(exp_err ? {"R8 sync error after ", pend_lbl} : {"R9 sync error after ", pend_lbl},
                    DW'(sync_err), DW'(exp_err));
            end
            if (i == 2) chk({"R7 done width after ", pend_lbl}, DW'(frame_done), '0);
            sdata  = bit_at(i, tg, dd);
            strobe = (i < 15) || (i == cut - 1);
        end
        pend      = (cut == 256);
        pend_tag  = tg;
        pend_data = dd;
        pend_lbl  = lbl;
        if (cut != 256) exp_err = 1'b1;
    endtask

    // R10: outputs are cleared while reset is held.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 ready in reset", DW'(dev_ready), '0);
        chk("R10 valid in reset", DW'(slot_valid), '0);
        chk("R10 data in reset", slot_data, '0);
        chk("R10 done and error in reset", DW'({frame_done, sync_err}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        strobe = 1'b1;  // first rise after reset: R9, no error
    endtask

    // R1 R2 R3 R4: every slot valid with distinct data.
    task automatic t_all_valid();
        send_frame("R1 all valid", mk_tag(1'b1, '1, 3'b000), pattern(1), 256);
    endtask

    // R5: odd slots valid only; even slots must keep their words.
    task automatic t_some_valid();
        send_frame("R5 odd slots", mk_tag(1'b1, 12'h555, 3'b000), pattern(2), 256);
    endtask

    // R3: device not ready, only slot 12 valid.
    task automatic t_ready_low();
        send_frame("R3 ready low", mk_tag(1'b0, 12'h800, 3'b000), pattern(3), 256);
    endtask

    // R6: only tag positions 13 to 15 set, data all ones.
    task automatic t_tail_bits();
        send_frame("R6 tail bits", mk_tag(1'b0, '0, 3'b111), '1, 256);
    endtask

    // R8: strobe rises at position 99, which cuts the frame short.
    task automatic t_misalign();
        send_frame("R8 cut frame", mk_tag(1'b1, '1, 3'b000), pattern(4), 100);
    endtask

    // R2 R8: the frame after the early rise decodes correctly.
    task automatic t_realigned();
        send_frame("R2 realigned", mk_tag(1'b1, 12'hA3C, 3'b000), pattern(5), 256);
    endtask

    // Flushes the last pending frame through its check.
    task automatic t_flush();
        send_frame("flush", '0, '0, 256);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, requirements R1 to R10 not completed");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_all_valid();
        t_some_valid();
        t_ready_low();
        t_tail_bits();
        t_misalign();
        t_realigned();
        t_flush();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule